// File: doc/BRIEF.md
# Serial Two-Channel DAC Frame Loader

This block sits on the host side of a dual-channel, serially loaded DAC. It takes a 12-bit output code and a channel mask in one valid/ready transfer. It then drives the converter's interface pins:
- an active-low select;
- a serial clock;
- a serial data line;
- one active-low load strobe per channel.

The code goes out as a 16-bit word, most significant bit first. Four zero pad bits lead the word and the code fills the twelve bits after them. Once the word has been sent and the select has been released, the block pulses the strobes named by the mask all together. When every strobe is high again and a recovery interval has passed, the block becomes ready for the next word.

Every timing limit of the converter is given as a parameter, counted in system-clock cycles. These limits are the clock high and low widths, the data setup and hold, the spacing from the last clock to the strobe, the strobe width and the recovery after the strobe. The sequencer holds each phase for exactly its derived count. Flow control on the input is plain back-pressure. The block is ready only while idle, so a request waits with its valid held until it is taken, and a new word is never started while one is still in progress.

Top module: `dac_frame_loader`

## Requirements
- R1: During and right after reset, the select is high, the serial clock is low, every load strobe is high and `in_ready` is high.
- R2: `in_ready` is high only while the block is idle. A word is taken on a clock edge where both `in_valid` and `in_ready` are high. While the block is busy, `in_valid`, `in_code` and `in_mask` have no effect. While idle with `in_valid` low, the select stays high.
- R3: Each word is 16 serial bits, sampled at the rising edges of the serial clock, most significant bit first. Bits 15..12 are zero and bits 11..0 carry `in_code`.
- R4: Each low phase of the serial clock within a word lasts LO = max(SCK_LO_CYC, SETUP_CYC) cycles. Each high phase lasts HI = max(SCK_HI_CYC, HOLD_CYC) cycles.
- R5: The serial data line changes only while the serial clock is low, and holds steady through every high phase.
- R6: The select goes low on the cycle after the word is taken and stays low up to the final falling edge of the serial clock. The serial clock is never high while the select is high.
- R7: After the select rises, the strobes stay high for LD_LEAD_CYC cycles. Then every strobe whose mask bit is set goes low together for LD_WIDTH_CYC cycles. Mask bit 0 drives `dac_ld_n[0]` and mask bit 1 drives `dac_ld_n[1]`.
- R8: A mask of zero still sends the full word with the same timing, but no strobe falls.
- R9: No load strobe is low while the select is low, so no strobe is ever low while bits are being shifted.
- R10: After the strobes return high, `in_ready` rises after LD_RECOV_CYC cycles. The busy time of one word is 16*(LO+HI) + LD_LEAD_CYC + LD_WIDTH_CYC + LD_RECOV_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A request word is offered |
| in_ready | output | 1 | Block is idle and will take the offered word |
| in_mask | input | N_CH | Channels whose load strobe pulses after the word |
| in_code | input | CODE_W | DAC code to send |
| dac_cs_n | output | 1 | Active-low select to the DAC |
| dac_sck | output | 1 | Serial clock; the DAC samples on its rising edge |
| dac_sdi | output | 1 | Serial data, MSB first |
| dac_ld_n | output | N_CH | Active-low per-channel load strobes |

## Verification
Every result is due at a fixed cycle offset from the accepting edge. The first low phase starts on the next cycle. Bit k is sampled at the rise that ends cycle k*(LO+HI)+LO. The select rises after 16*(LO+HI) cycles, the strobe falls LD_LEAD_CYC cycles after that, and `in_ready` comes back after the full busy count given in R10. The bench samples every output on the falling clock edge and counts each phase length in those samples: clock low and high runs, lead cycles before the strobe, strobe-low cycles per channel, recovery cycles and total busy cycles. After `in_ready` returns, it compares each count with the value that the requirement formulas give for the default parameters.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_GAP,
    ST_STROBE,
    ST_RECOV
  } dacld_state_e;

  // larger of two cycle counts, never below one cycle
  function automatic int cyc_max(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : m;
  endfunction

endpackage

// File: rtl/dacld_pacer.sv
module dacld_pacer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dacld_serializer.sv
module dacld_serializer #(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              sdo,
  output logic              last
);

  localparam int PAD_W = FRAME_W - CODE_W;
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= FRAME_W'(code);
      idx_q  <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign sdo  = sreg_q[FRAME_W-1];
  assign last = (idx_q == LAST_IDX);

  generate
    if (PAD_W > 0) begin : g_pad_chk
      // R3
      frame_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sreg_q[FRAME_W-1 -: PAD_W] == '0));
    end
  endgenerate

  // R3
  no_shift_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && last) |-> 1'b0);

endmodule

// File: rtl/dacld_seq.sv
module dacld_seq
  import dacld_pkg::*;
#(
  parameter int N_CH    = 2,
  parameter int CNT_W   = 4,
  parameter int LO_PH   = 5,
  parameter int HI_PH   = 5,
  parameter int LEAD_PH = 3,
  parameter int STB_PH  = 3,
  parameter int REC_PH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N_CH-1:0]  in_mask,
  output logic             in_ready,
  input  logic             tmr_expired,
  input  logic             bit_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ser_load,
  output logic             ser_shift,
  output logic             cs_n,
  output logic             sck,
  output logic [N_CH-1:0]  ld_n
);

  localparam logic [CNT_W-1:0] LO_V   = CNT_W'(LO_PH - 1);
  localparam logic [CNT_W-1:0] HI_V   = CNT_W'(HI_PH - 1);
  localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD_PH - 1);
  localparam logic [CNT_W-1:0] STB_V  = CNT_W'(STB_PH - 1);
  localparam logic [CNT_W-1:0] REC_V  = CNT_W'(REC_PH - 1);

  dacld_state_e    state_q, state_d;
  logic [N_CH-1:0] mask_q;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ser_load  = 1'b0;
    ser_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid) begin
        state_d  = ST_LO;
        tmr_load = 1'b1;
        tmr_val  = LO_V;
        ser_load = 1'b1;
      end
      ST_LO: if (tmr_expired) begin
        state_d  = ST_HI;
        tmr_load = 1'b1;
        tmr_val  = HI_V;
      end
      ST_HI: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (bit_last) begin
          state_d = ST_GAP;
          tmr_val = LEAD_V;
        end else begin
          state_d   = ST_LO;
          tmr_val   = LO_V;
          ser_shift = 1'b1;
        end
      end
      ST_GAP: if (tmr_expired) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = STB_V;
      end
      ST_STROBE: if (tmr_expired) begin
        state_d  = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = REC_V;
      end
      ST_RECOV: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && in_valid) mask_q <= in_mask;
    end
  end

  assign in_ready = (state_q == ST_IDLE);
  assign cs_n     = !(state_q == ST_LO || state_q == ST_HI);
  assign sck      = (state_q == ST_HI);
  assign ld_n     = (state_q == ST_STROBE) ? ~mask_q : '1;

  // R2
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  busy_holds_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (in_ready || $stable(mask_q)));

endmodule

// File: rtl/dac_frame_loader.sv
module dac_frame_loader
  import dacld_pkg::*;
#(
  parameter int CODE_W       = 12,
  parameter int FRAME_W      = 16,
  parameter int N_CH         = 2,
  parameter int SCK_HI_CYC   = 5,
  parameter int SCK_LO_CYC   = 5,
  parameter int SETUP_CYC    = 1,
  parameter int HOLD_CYC     = 3,
  parameter int LD_LEAD_CYC  = 3,
  parameter int LD_WIDTH_CYC = 3,
  parameter int LD_RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_CH-1:0]   in_mask,
  input  logic [CODE_W-1:0] in_code,
  output logic              dac_cs_n,
  output logic              dac_sck,
  output logic              dac_sdi,
  output logic [N_CH-1:0]   dac_ld_n
);

  localparam int LO_PH   = cyc_max(SCK_LO_CYC, SETUP_CYC);
  localparam int HI_PH   = cyc_max(SCK_HI_CYC, HOLD_CYC);
  localparam int LEAD_PH = cyc_max(LD_LEAD_CYC, 1);
  localparam int STB_PH  = cyc_max(LD_WIDTH_CYC, 1);
  localparam int REC_PH  = cyc_max(LD_RECOV_CYC, 1);
  localparam int MAX_PH  = cyc_max(cyc_max(LO_PH, HI_PH),
                                   cyc_max(cyc_max(LEAD_PH, STB_PH), REC_PH));
  localparam int CNT_W   = $clog2(MAX_PH + 1);

  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             ser_load, ser_shift, bit_last;

  dacld_seq #(
    .N_CH(N_CH), .CNT_W(CNT_W), .LO_PH(LO_PH), .HI_PH(HI_PH),
    .LEAD_PH(LEAD_PH), .STB_PH(STB_PH), .REC_PH(REC_PH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_mask(in_mask), .in_ready(in_ready),
    .tmr_expired(tmr_expired), .bit_last(bit_last),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ser_load(ser_load), .ser_shift(ser_shift),
    .cs_n(dac_cs_n), .sck(dac_sck), .ld_n(dac_ld_n)
  );

  dacld_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  dacld_serializer #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .load(ser_load), .code(in_code), .shift(ser_shift),
    .sdo(dac_sdi), .last(bit_last)
  );

  // run-length counters used only by the pin-level checks below
  logic [15:0] hi_run_q, ld_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      ld_run_q <= '0;
    end else begin
      hi_run_q <= dac_sck ? ((hi_run_q == 16'hFFFF) ? hi_run_q : hi_run_q + 1'b1) : '0;
      ld_run_q <= (dac_ld_n != '1) ?
                  ((ld_run_q == 16'hFFFF) ? ld_run_q : ld_run_q + 1'b1) : '0;
    end
  end

  // R4
  sck_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sck) |-> (hi_run_q == 16'(HI_PH)));

  // R5
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sck |=> (!dac_sck || $stable(dac_sdi)));

  // R6
  sck_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sck |-> !dac_cs_n);

  // R9
  strobe_clear_of_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> (dac_ld_n == '1));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dac_ld_n == '1) && ($past(dac_ld_n) != '1)) |-> (ld_run_q == 16'(STB_PH)));

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (dac_cs_n && !dac_sck && (dac_ld_n == '1)));

endmodule

// File: tb/test_dac_frame_loader.sv
`timescale 1ns/1ps
module test_dac_frame_loader;

  localparam int LO   = 5;   // max(SCK_LO_CYC=5, SETUP_CYC=1)
  localparam int HI   = 5;   // max(SCK_HI_CYC=5, HOLD_CYC=3)
  localparam int LDS  = 3;
  localparam int LDW  = 3;
  localparam int REC  = 4;
  localparam int BUSY = 16 * (LO + HI) + LDS + LDW + REC;
  localparam int NVEC = 6;
  // {mask[1:0], code[11:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'b01, 12'hA5C}, {2'b10, 12'h3C1}, {2'b11, 12'hFFF},
    {2'b00, 12'h7E2}, {2'b11, 12'h000}, {2'b01, 12'h800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mask = '0;
  logic [11:0] in_code = '0;
  logic        dac_cs_n, dac_sck, dac_sdi;
  logic [1:0]  dac_ld_n;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  dac_frame_loader i_dac_frame_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_code(in_code), .dac_cs_n(dac_cs_n),
    .dac_sck(dac_sck), .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n)
  );

  // behavioural receiver and phase monitor, sampled on the falling edge
  logic [15:0] rx;
  int rx_n, lo_run, hi_run, bad_lo, bad_hi, bad_sdi, bad_cs, bad_ld;
  int busy, pre_ld, post_ld, ld_started, cs_idle_low;
  int ld_cnt [2];
  logic prev_sck = 1'b0, prev_sdi = 1'b0;

  always @(negedge clk) begin
    if (in_ready && in_valid) begin
      rx = '0; rx_n = 0; lo_run = 0; hi_run = 0; bad_lo = 0; bad_hi = 0;
      bad_sdi = 0; bad_cs = 0; bad_ld = 0; busy = 0; pre_ld = 0;
      post_ld = 0; ld_started = 0; ld_cnt[0] = 0; ld_cnt[1] = 0;
    end else begin
      if (dac_sck && !prev_sck) begin
        if (!dac_cs_n) begin rx = {rx[14:0], dac_sdi}; rx_n++; end
        if (lo_run != LO) bad_lo++;
        lo_run = 0;
      end else if (!dac_cs_n && !dac_sck) lo_run++;
      if (!dac_sck && prev_sck) begin
        if (hi_run != HI) bad_hi++;
        hi_run = 0;
      end
      if (dac_sck) hi_run++;
      if (dac_sck && prev_sck && (dac_sdi != prev_sdi)) bad_sdi++;
      if (dac_sck && dac_cs_n) bad_cs++;
      if ((dac_ld_n != 2'b11) && !dac_cs_n) bad_ld++;
      for (int ch = 0; ch < 2; ch++) if (!dac_ld_n[ch]) ld_cnt[ch]++;
      if (!in_ready) busy++;
      if (in_ready && !in_valid && !dac_cs_n) cs_idle_low++;
      if (dac_ld_n != 2'b11) ld_started = 1;
      else if (!in_ready && dac_cs_n) begin
        if (ld_started != 0) post_ld++; else pre_ld++;
      end
    end
    prev_sck = dac_sck;
    prev_sdi = dac_sdi;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic [11:0] c);
    @(posedge clk); #1;
    in_mask = m; in_code = c; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_code = ~c; in_mask = ~m;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic verify(input logic [1:0] m, input logic [11:0] c);
    chk("R3 code", int'(rx[11:0]), int'(c));
    chk("R3 pad bits", int'(rx[15:12]), 0);
    chk("R3 bit count", rx_n, 16);
    chk("R4 phase widths", bad_lo + bad_hi, 0);
    chk("R5 sdi steady in high phase", bad_sdi, 0);
    chk("R6 sck outside select", bad_cs, 0);
    chk("R9 strobe during shift", bad_ld, 0);
    chk("R7 strobe A width", ld_cnt[0], m[0] ? LDW : 0);
    chk("R7 strobe B width", ld_cnt[1], m[1] ? LDW : 0);
    chk("R8 lead cycles", pre_ld, (m != 2'b00) ? LDS : LDS + LDW + REC);
    chk("R10 recovery", post_ld, (m != 2'b00) ? REC : 0);
    chk("R10 busy cycles", busy, BUSY);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cs_idle_low = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n in reset", int'(dac_cs_n), 1);
    chk("R1 sck in reset", int'(dac_sck), 0);
    chk("R1 ld_n in reset", int'(dac_ld_n), 3);
    chk("R1 ready in reset", int'(in_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(in_ready), 1);
    chk("R1 ld_n after reset", int'(dac_ld_n), 3);

    // R2 idle with valid low: nothing starts
    repeat (20) @(negedge clk);
    chk("R2 idle select stays high", cs_idle_low, 0);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][13:12], VEC[i][11:0]);
      verify(VEC[i][13:12], VEC[i][11:0]);
    end

    // R2 valid held while busy with other data is not consumed
    @(posedge clk); #1;
    in_mask = 2'b01; in_code = 12'h5A3; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_mask = 2'b10; in_code = 12'hC3E;
    repeat (40) @(negedge clk);
    chk("R2 ready low while busy", int'(in_ready), 0);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    verify(2'b01, 12'h5A3);
    repeat (15) @(negedge clk);
    chk("R2 no second word taken", int'(dac_cs_n), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule